// File: doc/BRIEF.md
# Signed Multiplier with Operand Registers

This block holds the operands and result of a signed 16 by 16 multiplier. A 16-bit x register and the upper half of a 32-bit y register feed the multiplier. When the multiply enable is high, the 32-bit product is written into a product register p at the next clock edge. Each register half has its own write port: x, y-high, y-low, p-high and p-low. A downstream ALU can therefore load or patch any half directly.

Two level-sensitive mode inputs change how the y register is loaded. With the keep-low mode at 0, a y-high load clears y-low to zero. With it at 1, y-low is left alone. With the square mode set, every y-high load also copies the same value into x, so the next multiply squares that value. The p register never clears or changes its low half on a high-half write, whatever the modes are. The block also presents both y and p to the ALU as 36-bit values: the 32-bit word with its sign bit copied into four guard bits.

Top module: `mul_operand_unit`

## Requirements
- R1: When mulEn is high, p takes the two's-complement product of x and y-high at the next clock edge. The operands are the register values held before that edge, so a load issued in the same cycle does not affect this product.
- R2: When squareMode is 1, a y-high load also writes the same 16-bit value into x. If xWrEn is asserted in the same cycle, the copied y-high value wins.
- R3: When keepLoMode is 0, a y-high load without a y-low load clears y-low to zero.
- R4: When keepLoMode is 1, a y-high load leaves y-low unchanged.
- R5: A y-low load never changes y-high. When y-high and y-low are loaded in the same cycle, y-low takes the written value and is not cleared.
- R6: A p-high write never changes p-low, for any value of keepLoMode and squareMode.
- R7: A direct write to a half of p overrides the product for that half only. The other half still takes the product when mulEn is high.
- R8: pExt equals pOut with bit 31 copied into bits 35:32. yExt equals yOut with bit 31 copied into bits 35:32.
- R9: Reset (rstN low) sets x, y and p to zero.
- R10: p holds its value in any cycle with no multiply and no p write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| xWrEn | input | 1 | Load x from xWrData |
| xWrData | input | 16 | Data for x |
| yHiWrEn | input | 1 | Load y-high from yHiWrData |
| yHiWrData | input | 16 | Data for y-high |
| yLoWrEn | input | 1 | Load y-low from yLoWrData |
| yLoWrData | input | 16 | Data for y-low |
| pHiWrEn | input | 1 | Load p-high from pHiWrData |
| pHiWrData | input | 16 | Data for p-high |
| pLoWrEn | input | 1 | Load p-low from pLoWrData |
| pLoWrData | input | 16 | Data for p-low |
| mulEn | input | 1 | Update p with x times y-high |
| keepLoMode | input | 1 | 1: y-high loads keep y-low; 0: they clear it |
| squareMode | input | 1 | 1: y-high loads are copied into x |
| xOut | output | 16 | Current x register |
| yOut | output | 32 | Current y register, high half in bits 31:16 |
| pOut | output | 32 | Current product register |
| yExt | output | 36 | y sign-extended to 36 bits |
| pExt | output | 36 | p sign-extended to 36 bits |

## Verification
Every register is visible on the ports in the cycle after it is written. A wrong clear, a missed copy or a disturbed half therefore shows on xOut, yOut or pOut at the first sample after the offending edge. A wrong x left behind by a failed square-mode copy shows a second time one multiply later, as a wrong product. Stale or early operand use shows as a product that matches neither the old nor the new operands.

// File: rtl/mul_operand_pkg.sv
package mul_operand_pkg;
  typedef struct packed {
    logic loadX;
    logic xFromY;
    logic loadYHi;
    logic loadYLo;
    logic clearYLo;
    logic loadPHi;
    logic loadPLo;
    logic mulUpd;
  } mulStrobes_t;
endpackage

// File: rtl/mul_operand_ctrl.sv
module mul_operand_ctrl
  import mul_operand_pkg::*;
(
  input  logic        xWrEn,
  input  logic        yHiWrEn,
  input  logic        yLoWrEn,
  input  logic        pHiWrEn,
  input  logic        pLoWrEn,
  input  logic        mulEn,
  input  logic        keepLoMode,
  input  logic        squareMode,
  output mulStrobes_t strb
);
  always_comb begin
    strb          = '0;
    // Square mode: a y-high load also feeds x, and overrides a plain x load.
    strb.xFromY   = squareMode && yHiWrEn;
    strb.loadX    = xWrEn || strb.xFromY;
    strb.loadYHi  = yHiWrEn;
    strb.loadYLo  = yLoWrEn;
    // A y-low write in the same cycle beats the clear.
    strb.clearYLo = yHiWrEn && !keepLoMode && !yLoWrEn;
    strb.loadPHi  = pHiWrEn;
    strb.loadPLo  = pLoWrEn;
    strb.mulUpd   = mulEn;
  end
endmodule

// File: rtl/mul_operand_dp.sv
module mul_operand_dp
  import mul_operand_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobes_t     strb,
  input  logic [DW-1:0]   xWrData,
  input  logic [DW-1:0]   yHiWrData,
  input  logic [DW-1:0]   yLoWrData,
  input  logic [DW-1:0]   pHiWrData,
  input  logic [DW-1:0]   pLoWrData,
  output logic [DW-1:0]   xOut,
  output logic [2*DW-1:0] yOut,
  output logic [2*DW-1:0] pOut,
  output logic [2*DW+GW-1:0] yExt,
  output logic [2*DW+GW-1:0] pExt
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] xReg, yHi, yLo, pHi, pLo;
  logic signed [PW-1:0] prod;
  logic [DW-1:0] xNext, pHiNext, pLoNext;

  assign prod = $signed(xReg) * $signed(yHi);

  always_comb begin
    xNext = xReg;
    if (strb.xFromY)     xNext = yHiWrData;
    else if (strb.loadX) xNext = xWrData;
  end

  assign pHiNext = strb.loadPHi ? pHiWrData : (strb.mulUpd ? prod[PW-1:DW] : pHi);
  assign pLoNext = strb.loadPLo ? pLoWrData : (strb.mulUpd ? prod[DW-1:0]  : pLo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg <= '0;
      yHi  <= '0;
      yLo  <= '0;
      pHi  <= '0;
      pLo  <= '0;
    end else begin
      xReg <= xNext;
      if (strb.loadYHi)       yHi <= yHiWrData;
      if (strb.loadYLo)       yLo <= yLoWrData;
      else if (strb.clearYLo) yLo <= '0;
      pHi <= pHiNext;
      pLo <= pLoNext;
    end
  end

  assign xOut = xReg;
  assign yOut = {yHi, yLo};
  assign pOut = {pHi, pLo};
  assign yExt = {{GW{yHi[DW-1]}}, yHi, yLo};
  assign pExt = {{GW{pHi[DW-1]}}, pHi, pLo};

  // R6: the low half of p survives a high-half write
  a_r6_p_lo_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPHi && !strb.loadPLo && !strb.mulUpd |=> $stable(pLo));

  // R10: no update strobe, p holds
  a_r10_p_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPHi && !strb.loadPLo && !strb.mulUpd |=> $stable(pOut));
endmodule

// File: rtl/mul_operand_unit.sv
module mul_operand_unit
  import mul_operand_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xWrEn,
  input  logic [15:0] xWrData,
  input  logic        yHiWrEn,
  input  logic [15:0] yHiWrData,
  input  logic        yLoWrEn,
  input  logic [15:0] yLoWrData,
  input  logic        pHiWrEn,
  input  logic [15:0] pHiWrData,
  input  logic        pLoWrEn,
  input  logic [15:0] pLoWrData,
  input  logic        mulEn,
  input  logic        keepLoMode,
  input  logic        squareMode,
  output logic [15:0] xOut,
  output logic [31:0] yOut,
  output logic [31:0] pOut,
  output logic [35:0] yExt,
  output logic [35:0] pExt
);
  mulStrobes_t strb;

  mul_operand_ctrl u_ctrl (
    .xWrEn(xWrEn), .yHiWrEn(yHiWrEn), .yLoWrEn(yLoWrEn),
    .pHiWrEn(pHiWrEn), .pLoWrEn(pLoWrEn), .mulEn(mulEn),
    .keepLoMode(keepLoMode), .squareMode(squareMode), .strb(strb)
  );

  mul_operand_dp #(.DW(16), .GW(4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .xWrData(xWrData), .yHiWrData(yHiWrData), .yLoWrData(yLoWrData),
    .pHiWrData(pHiWrData), .pLoWrData(pLoWrData),
    .xOut(xOut), .yOut(yOut), .pOut(pOut), .yExt(yExt), .pExt(pExt)
  );

  // R1: full product lands in p from the pre-edge operands
  a_r1_product: assert property (@(posedge clk) disable iff (!rstN)
    mulEn && !pHiWrEn && !pLoWrEn |=>
      $signed(pOut) == $signed($past(xOut)) * $signed($past(yOut[31:16])));

  // R2: square mode mirrors the y-high load into x
  a_r2_square_copy: assert property (@(posedge clk) disable iff (!rstN)
    squareMode && yHiWrEn |=> xOut == yOut[31:16]);

  // R3: y-high load clears y-low when not kept
  a_r3_clear_lo: assert property (@(posedge clk) disable iff (!rstN)
    yHiWrEn && !keepLoMode && !yLoWrEn |=> yOut[15:0] == 16'h0);

  // R4: y-high load keeps y-low in keep mode
  a_r4_keep_lo: assert property (@(posedge clk) disable iff (!rstN)
    yHiWrEn && keepLoMode && !yLoWrEn |=> $stable(yOut[15:0]));

  // R5: y-low load leaves y-high alone
  a_r5_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rstN)
    yLoWrEn && !yHiWrEn |=> $stable(yOut[31:16]));
endmodule

// File: tb/sim_mul_operand_unit.sv
module sim_mul_operand_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xWrEn = 0, yHiWrEn = 0, yLoWrEn = 0, pHiWrEn = 0, pLoWrEn = 0;
  logic mulEn = 0, keepLoMode = 0, squareMode = 0;
  logic [15:0] xWrData = 0, yHiWrData = 0, yLoWrData = 0, pHiWrData = 0, pLoWrData = 0;
  logic [15:0] xOut;
  logic [31:0] yOut, pOut;
  logic [35:0] yExt, pExt;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mul_operand_unit u0 (
    .clk(clk), .rstN(rstN),
    .xWrEn(xWrEn), .xWrData(xWrData),
    .yHiWrEn(yHiWrEn), .yHiWrData(yHiWrData),
    .yLoWrEn(yLoWrEn), .yLoWrData(yLoWrData),
    .pHiWrEn(pHiWrEn), .pHiWrData(pHiWrData),
    .pLoWrEn(pLoWrEn), .pLoWrData(pLoWrData),
    .mulEn(mulEn), .keepLoMode(keepLoMode), .squareMode(squareMode),
    .xOut(xOut), .yOut(yOut), .pOut(pOut), .yExt(yExt), .pExt(pExt)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        xEn;  logic [15:0] xD;
    logic        yhEn; logic [15:0] yhD;
    logic        ylEn; logic [15:0] ylD;
    logic        phEn; logic [15:0] phD;
    logic        plEn; logic [15:0] plD;
    logic        mul;  logic keep; logic sq;
    logic [15:0] eX;   logic [31:0] eY; logic [31:0] eP;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{"R1 ",1,16'h0003,1,16'h0005,0,16'h0,0,16'h0,0,16'h0,1,0,0,16'h0003,32'h00050000,32'h00000000},
    '{"R1 ",0,16'h0,0,16'h0,0,16'h0,0,16'h0,0,16'h0,1,0,0,16'h0003,32'h00050000,32'h0000000F},
    '{"R5 ",0,16'h0,0,16'h0,1,16'h1234,0,16'h0,0,16'h0,0,0,0,16'h0003,32'h00051234,32'h0000000F},
    '{"R3 ",0,16'h0,1,16'hFFFE,0,16'h0,0,16'h0,0,16'h0,0,0,0,16'h0003,32'hFFFE0000,32'h0000000F},
    '{"R1 ",0,16'h0,0,16'h0,0,16'h0,0,16'h0,0,16'h0,1,0,0,16'h0003,32'hFFFE0000,32'hFFFFFFFA},
    '{"R10",0,16'h0,0,16'h0,1,16'hABCD,0,16'h0,0,16'h0,0,0,0,16'h0003,32'hFFFEABCD,32'hFFFFFFFA},
    '{"R4 ",0,16'h0,1,16'h0007,0,16'h0,0,16'h0,0,16'h0,0,1,0,16'h0003,32'h0007ABCD,32'hFFFFFFFA},
    '{"R2 ",0,16'h0,1,16'h8000,0,16'h0,0,16'h0,0,16'h0,0,1,1,16'h8000,32'h8000ABCD,32'hFFFFFFFA},
    '{"R1 ",0,16'h0,0,16'h0,0,16'h0,0,16'h0,0,16'h0,1,1,1,16'h8000,32'h8000ABCD,32'h40000000},
    '{"R7 ",0,16'h0,0,16'h0,0,16'h0,0,16'h0,1,16'h2222,0,0,0,16'h8000,32'h8000ABCD,32'h40002222},
    '{"R6 ",0,16'h0,0,16'h0,0,16'h0,1,16'h9999,0,16'h0,0,0,1,16'h8000,32'h8000ABCD,32'h99992222},
    '{"R10",1,16'h0003,0,16'h0,0,16'h0,0,16'h0,0,16'h0,0,0,0,16'h0003,32'h8000ABCD,32'h99992222},
    '{"R7 ",0,16'h0,0,16'h0,0,16'h0,1,16'h0001,0,16'h0,1,0,0,16'h0003,32'h8000ABCD,32'h00018000},
    '{"R2 ",1,16'h1111,1,16'h0002,0,16'h0,0,16'h0,0,16'h0,0,0,1,16'h0002,32'h00020000,32'h00018000},
    '{"R5 ",0,16'h0,1,16'h0009,1,16'h5555,0,16'h0,0,16'h0,0,0,0,16'h0002,32'h00095555,32'h00018000},
    '{"R7 ",0,16'h0,0,16'h0,0,16'h0,0,16'h0,1,16'h7777,1,0,0,16'h0002,32'h00095555,32'h00007777}
  };

  task automatic check(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    xWrEn = 0; yHiWrEn = 0; yLoWrEn = 0; pHiWrEn = 0; pLoWrEn = 0; mulEn = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    check("R9", "x after reset", {20'h0, xOut}, 36'h0);
    check("R9", "y after reset", {4'h0, yOut}, 36'h0);
    check("R9", "p after reset", {4'h0, pOut}, 36'h0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      xWrEn = TBL[i].xEn;   xWrData = TBL[i].xD;
      yHiWrEn = TBL[i].yhEn; yHiWrData = TBL[i].yhD;
      yLoWrEn = TBL[i].ylEn; yLoWrData = TBL[i].ylD;
      pHiWrEn = TBL[i].phEn; pHiWrData = TBL[i].phD;
      pLoWrEn = TBL[i].plEn; pLoWrData = TBL[i].plD;
      mulEn = TBL[i].mul; keepLoMode = TBL[i].keep; squareMode = TBL[i].sq;
      @(negedge clk);
      check(string'(TBL[i].tag), $sformatf("vec %0d x", i), {20'h0, xOut}, {20'h0, TBL[i].eX});
      check(string'(TBL[i].tag), $sformatf("vec %0d y", i), {4'h0, yOut}, {4'h0, TBL[i].eY});
      check(string'(TBL[i].tag), $sformatf("vec %0d p", i), {4'h0, pOut}, {4'h0, TBL[i].eP});
    end
    idle();

    // R8: positive extension from the current state
    @(negedge clk);
    check("R8", "pExt positive", pExt, 36'h000007777);
    check("R8", "yExt positive", yExt, 36'h000095555);

    // R8 and R6: negative p-high, low half kept
    pHiWrEn = 1; pHiWrData = 16'hC000; keepLoMode = 1; squareMode = 1;
    @(negedge clk); idle();
    check("R6", "p after high write", {4'h0, pOut}, 36'h0C0007777);
    check("R8", "pExt negative", pExt, 36'hFC0007777);

    // R8 and R4: negative y-high in keep mode, square copy into x
    yHiWrEn = 1; yHiWrData = 16'h9000;
    @(negedge clk); idle();
    check("R4", "y after keep load", {4'h0, yOut}, 36'h090005555);
    check("R8", "yExt negative", yExt, 36'hF90005555);
    check("R2", "x copy of y-high", {20'h0, xOut}, 36'h000009000);

    // R1: square of -28672 = 0x31000000
    mulEn = 1;
    @(negedge clk); idle();
    check("R1", "square product", {4'h0, pOut}, 36'h031000000);

    // R10: p holds over idle cycles
    repeat (3) @(negedge clk);
    check("R10", "p hold", {4'h0, pOut}, 36'h031000000);

    // R9: reset mid-run
    rstN = 0;
    @(negedge clk);
    check("R9", "x mid reset", {20'h0, xOut}, 36'h0);
    check("R9", "y mid reset", {4'h0, yOut}, 36'h0);
    check("R9", "p mid reset", {4'h0, pOut}, 36'h0);
    check("R8", "pExt in reset", pExt, 36'h0);
    rstN = 1;
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule